// File: doc/BRIEF.md
# Segmented Address Pointer Unit

This block holds sixteen 16-bit address registers and performs pointer arithmetic on them in one of two modes, chosen per operation by `segMode`. In flat mode a pointer is one register. In segmented mode a pointer occupies an even/odd register pair. The even (high) word carries a 7-bit segment number in bits 14:8. The odd (low) word carries a 16-bit offset. Arithmetic touches only the offset, so a pointer never crosses into a neighbouring segment. The offset wraps modulo 2^16.

The unit also converts between a register pair and a packed 32-bit address. In packed form bit 31 is a segmented marker, bits 30:24 hold the segment, bits 23:16 are zero and bits 15:0 hold the offset. It supports load-address updates (copy a pointer, then add a displacement), absolute loads with an optional base-register offset, and a plain word write used to set registers up. Each operation is qualified by `valid` and completes at the next rising clock edge. A combinational read port and the packed view of the register selected by `regA` expose the state.

Top module: `segptr_unit`

## Requirements
- R1: While reset is low and after it is released, every register reads 0 and `errFlag` is 0. `packedAddr` is 0 in flat mode and 0x80000000 in segmented mode.
- R2: With `segMode`=1, `packedAddr` is {1, bits 14:8 of register (regA with bit 0 cleared), 8'h00, register (regA with bit 0 set)}.
- R3: With `segMode`=0, `packedAddr` is {16'h0000, register regA}.
- R4: Write-packed (opCode 6) in segmented mode changes only bits 14:8 of the even register, setting them from `addrIn[30:24]`; its bit 15 and bits 7:0 keep their values. The odd register receives `addrIn[15:0]`. In flat mode it writes `addrIn[15:0]` to regA.
- R5: Add (opCode 1) and subtract (opCode 2) in segmented mode apply `stepIn` only to the odd register of the pair, modulo 2^16. The even register never changes.
- R6: Add and subtract in flat mode apply `stepIn` to register regA itself, odd or even, modulo 2^16.
- R7: Load-address with displacement (opCode 3) copies the source pointer regB to regA and adds `stepIn` to the offset only. In segmented mode the source is the full pair; in flat mode it is one word.
- R8: Absolute load (opCode 4) writes `addrIn[31:16]` to the even register and `addrIn[15:0]` to the odd register in segmented mode. In flat mode it writes `addrIn[15:0]` to regA.
- R9: Indexed absolute load (opCode 5) behaves as opCode 4 and then adds the pre-operation value of register regB to the offset word only, modulo 2^16.
- R10: In segmented mode, opCodes 1 to 6 with an odd regA, or opCode 3 with an odd regB, change no register. They raise `errFlag` for exactly the one cycle after the strobe.
- R11: When `valid` is 0, no register changes, whatever the other inputs are.
- R12: Word write (opCode 7) loads `stepIn` into register regA in either mode and never raises `errFlag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Qualifies opCode, regA, regB, stepIn and addrIn |
| segMode | input | 1 | 1 = segmented pair pointers, 0 = flat single-word pointers |
| opCode | input | 3 | Operation select (codes in R4 to R12; 0 = idle) |
| regA | input | 4 | Target pointer register, also selects the packed view |
| regB | input | 4 | Source pointer (opCode 3) or base register (opCode 5) |
| stepIn | input | 16 | Step, displacement or word-write data |
| addrIn | input | 32 | Packed or raw absolute address |
| rdIdx | input | 4 | Read-port register index |
| rdData | output | 16 | Contents of register rdIdx |
| packedAddr | output | 32 | Packed address of the pointer selected by regA |
| errFlag | output | 1 | One-cycle pulse for an illegal pair index |

## Verification
The sweeps deliberately place offsets at 0xFFFF and 0x0000 before stepping by 1, 0x8000 and 0xFFFF. A design that let the carry leak into the segment word would show a changed even register. Write-packed is driven with addresses whose bits 23:16 and bit 31 are junk, against high words whose bit 15 and low byte are set. A design that overwrote the whole high word, or took the segment from the wrong bits, shows a mismatch there. Every operation is repeated with odd target and source indices in segmented mode. This exposes a design that silently rounds the index, writes a stray register, or holds the error flag high for more than one cycle. Copies where source and target coincide, and base-indexed loads whose base is the target itself, check that old values are read before they are overwritten.

// File: rtl/segptr_pkg.sv
package segptr_pkg;
  localparam int NUM_REGS = 16;
  localparam int WORD_W   = 16;
  localparam int SEG_W    = 7;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int PACK_W   = 2 * WORD_W;
  localparam int SEG_LSB  = WORD_W - 1 - SEG_W;   // segment field in high word
  localparam int PSEG_LSB = PACK_W - 1 - SEG_W;   // segment field in packed form

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_ADD      = 3'd1,
    OP_SUB      = 3'd2,
    OP_LDA_DISP = 3'd3,
    OP_LDA_ABS  = 3'd4,
    OP_LDA_ABSX = 3'd5,
    OP_WR_PACK  = 3'd6,
    OP_WR_WORD  = 3'd7
  } ptrOp_e;

  typedef enum logic [1:0] {LO_REG, LO_ADDR, LO_STEP} loSrc_e;
  typedef enum logic [1:0] {HI_REG, HI_ADDR, HI_MERGE} hiSrc_e;
  typedef enum logic [1:0] {ADJ_NONE, ADJ_ADD, ADJ_SUB} adj_e;

  typedef struct packed {
    logic             wrHi;
    logic             wrLo;
    logic [IDX_W-1:0] hiIdx;
    logic [IDX_W-1:0] loIdx;
    logic [IDX_W-1:0] hiRdIdx;
    logic [IDX_W-1:0] loRdIdx;
    logic [IDX_W-1:0] baseIdx;
    hiSrc_e           hiSrc;
    loSrc_e           loSrc;
    adj_e             adj;
    logic             useBase;
    logic             err;
  } strobe_t;
endpackage

// File: rtl/segptr_ctrl.sv
module segptr_ctrl
  import segptr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             valid,
  input  logic             segMode,
  input  logic [2:0]       opCode,
  input  logic [IDX_W-1:0] regA,
  input  logic [IDX_W-1:0] regB,
  output strobe_t          st,
  output logic             errFlag
);
  ptrOp_e           op;
  logic [IDX_W-1:0] evenA, oddA, evenB, oddB, loTarget;
  logic             pairOp, badIdx;

  assign op       = ptrOp_e'(opCode);
  assign evenA    = {regA[IDX_W-1:1], 1'b0};
  assign oddA     = {regA[IDX_W-1:1], 1'b1};
  assign evenB    = {regB[IDX_W-1:1], 1'b0};
  assign oddB     = {regB[IDX_W-1:1], 1'b1};
  assign loTarget = segMode ? oddA : regA;
  assign pairOp   = segMode && (op != OP_IDLE) && (op != OP_WR_WORD);
  assign badIdx   = pairOp && (regA[0] || ((op == OP_LDA_DISP) && regB[0]));

  always_comb begin
    st         = '0;
    st.hiSrc   = HI_REG;
    st.loSrc   = LO_REG;
    st.adj     = ADJ_NONE;
    st.loIdx   = loTarget;
    st.hiIdx   = evenA;
    st.loRdIdx = loTarget;
    st.hiRdIdx = evenB;
    st.baseIdx = regB;
    st.err     = valid && badIdx;
    if (valid && !badIdx) begin
      unique case (op)
        OP_ADD, OP_SUB: begin
          st.wrLo = 1'b1;
          st.adj  = (op == OP_ADD) ? ADJ_ADD : ADJ_SUB;
        end
        OP_LDA_DISP: begin
          st.wrLo    = 1'b1;
          st.wrHi    = segMode;
          st.loRdIdx = segMode ? oddB : regB;
          st.adj     = ADJ_ADD;
        end
        OP_LDA_ABS, OP_LDA_ABSX: begin
          st.wrLo    = 1'b1;
          st.wrHi    = segMode;
          st.loSrc   = LO_ADDR;
          st.hiSrc   = HI_ADDR;
          st.useBase = (op == OP_LDA_ABSX);
          st.adj     = (op == OP_LDA_ABSX) ? ADJ_ADD : ADJ_NONE;
        end
        OP_WR_PACK: begin
          st.wrLo  = 1'b1;
          st.wrHi  = segMode;
          st.loSrc = LO_ADDR;
          st.hiSrc = HI_MERGE;
        end
        OP_WR_WORD: begin
          st.wrLo  = 1'b1;
          st.loIdx = regA;
          st.loSrc = LO_STEP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= st.err;
  end

  // R10: an odd pair index under a strobe produces the error pulse next cycle
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (valid && segMode && regA[0] && (opCode != 3'd0) && (opCode != 3'd7)) |=> errFlag);

  // R10: the pulse lasts one cycle when no new strobe arrives
  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !valid) |=> !errFlag);

  // R11: no strobe, no write request
  assert_idle_nowrite_R11: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> !(st.wrHi || st.wrLo));
endmodule

// File: rtl/segptr_dp.sv
module segptr_dp
  import segptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              segMode,
  input  logic [IDX_W-1:0]  regA,
  input  logic [WORD_W-1:0] stepIn,
  input  logic [PACK_W-1:0] addrIn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdData,
  output logic [PACK_W-1:0] packedAddr
);
  logic [WORD_W-1:0] rf [NUM_REGS];
  logic [WORD_W-1:0] loBase, addend, loNext, hiNext, hiOld, loOld, partnerOld;
  logic [IDX_W-1:0]  evenA, oddA, partnerIdx;
  logic              unusedBits;

  assign unusedBits = ^{addrIn[PACK_W-1], addrIn[PSEG_LSB-1:WORD_W]};
  assign evenA      = {regA[IDX_W-1:1], 1'b0};
  assign oddA       = {regA[IDX_W-1:1], 1'b1};
  assign hiOld      = rf[st.hiIdx];
  assign loOld      = rf[st.loIdx];
  assign partnerIdx = st.loIdx ^ IDX_W'(1);
  assign partnerOld = rf[partnerIdx];

  always_comb begin
    unique case (st.loSrc)
      LO_ADDR: loBase = addrIn[WORD_W-1:0];
      LO_STEP: loBase = stepIn;
      default: loBase = rf[st.loRdIdx];
    endcase
    addend = st.useBase ? rf[st.baseIdx] : stepIn;
    unique case (st.adj)
      ADJ_ADD: loNext = loBase + addend;
      ADJ_SUB: loNext = loBase - addend;
      default: loNext = loBase;
    endcase
    unique case (st.hiSrc)
      HI_ADDR: hiNext = addrIn[PACK_W-1:WORD_W];
      HI_MERGE: begin
        hiNext = hiOld;
        hiNext[SEG_LSB +: SEG_W] = addrIn[PSEG_LSB +: SEG_W];
      end
      default: hiNext = rf[st.hiRdIdx];
    endcase
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    rf[g] <= '0;
      else if (st.wrHi && st.hiIdx == IDX_W'(g))    rf[g] <= hiNext;
      else if (st.wrLo && st.loIdx == IDX_W'(g))    rf[g] <= loNext;
    end
  end

  assign rdData = rf[rdIdx];

  always_comb begin
    packedAddr = '0;
    if (segMode) begin
      packedAddr[PACK_W-1]             = 1'b1;
      packedAddr[PSEG_LSB +: SEG_W]    = rf[evenA][SEG_LSB +: SEG_W];
      packedAddr[WORD_W-1:0]           = rf[oddA];
    end else begin
      packedAddr[WORD_W-1:0]           = rf[regA];
    end
  end

  // R5: a lone offset update leaves the partner (segment) word untouched
  assert_seg_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrLo && !st.wrHi && segMode && st.adj != ADJ_NONE)
      |=> rf[$past(partnerIdx)] == $past(partnerOld));

  // R5: in-place add wraps modulo the word width
  assert_offset_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrLo && st.adj == ADJ_ADD && !st.useBase && st.loSrc == LO_REG
       && st.loRdIdx == st.loIdx)
      |=> rf[$past(st.loIdx)] == WORD_W'($past(loOld) + $past(stepIn)));

  // R4: merging a segment keeps bit 15 and the low byte of the high word
  assert_merge_keep_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrHi && st.hiSrc == HI_MERGE)
      |=> (rf[$past(st.hiIdx)][WORD_W-1] == $past(hiOld[WORD_W-1]))
       && (rf[$past(st.hiIdx)][SEG_LSB-1:0] == $past(hiOld[SEG_LSB-1:0])));

  // R10: a rejected operation requests no write
  assert_err_nowrite_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.err |-> !(st.wrHi || st.wrLo));
endmodule

// File: rtl/segptr_unit.sv
module segptr_unit
  import segptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic              segMode,
  input  logic [2:0]        opCode,
  input  logic [IDX_W-1:0]  regA,
  input  logic [IDX_W-1:0]  regB,
  input  logic [WORD_W-1:0] stepIn,
  input  logic [PACK_W-1:0] addrIn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdData,
  output logic [PACK_W-1:0] packedAddr,
  output logic              errFlag
);
  strobe_t st;

  segptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .valid(valid), .segMode(segMode),
    .opCode(opCode), .regA(regA), .regB(regB), .st(st), .errFlag(errFlag)
  );

  segptr_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .segMode(segMode), .regA(regA),
    .stepIn(stepIn), .addrIn(addrIn), .rdIdx(rdIdx),
    .rdData(rdData), .packedAddr(packedAddr)
  );
endmodule

// File: tb/sim_segptr_unit.sv
`timescale 1ns/1ps
module sim_segptr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic        segMode = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [3:0]  regA = 4'd0, regB = 4'd0, rdIdx = 4'd0;
  logic [15:0] stepIn = 16'd0;
  logic [31:0] addrIn = 32'd0;
  logic [15:0] rdData;
  logic [31:0] packedAddr;
  logic        errFlag;

  int checks = 0;
  int errs = 0;
  logic [15:0] m [16];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  segptr_unit u0 (
    .clk(clk), .rstN(rstN), .valid(valid), .segMode(segMode), .opCode(opCode),
    .regA(regA), .regB(regB), .stepIn(stepIn), .addrIn(addrIn), .rdIdx(rdIdx),
    .rdData(rdData), .packedAddr(packedAddr), .errFlag(errFlag)
  );

  task automatic nextRnd(output logic [31:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = seed;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] expPack(input int i, input bit s);
    int ev = i & ~1;
    if (s) return {1'b1, m[ev][14:8], 8'h00, m[ev | 1]};
    return {16'h0000, m[i]};
  endfunction

  // reference behaviour taken from the requirements; returns expected error
  function automatic bit model(input int op, input int a, input int b,
                               input logic [15:0] stp, input logic [31:0] ad, input bit s);
    int ea = a & ~1, oa = a | 1, eb = b & ~1, ob = b | 1;
    int lo = s ? oa : a;
    logic [15:0] hv, lv, base;
    bit pair = s && (op >= 1) && (op <= 6);
    if (pair && ((a % 2) == 1 || (op == 3 && (b % 2) == 1))) return 1'b1;
    base = m[b];
    case (op)
      1: m[lo] = m[lo] + stp;
      2: m[lo] = m[lo] - stp;
      3: begin
        hv = m[eb]; lv = s ? m[ob] : m[b];
        if (s) m[ea] = hv;
        m[lo] = lv + stp;
      end
      4, 5: begin
        if (s) m[ea] = ad[31:16];
        m[lo] = ad[15:0] + ((op == 5) ? base : 16'h0000);
      end
      6: begin
        if (s) m[ea] = {m[ea][15], ad[30:24], m[ea][7:0]};
        m[lo] = ad[15:0];
      end
      7: m[a] = stp;
      default: ;
    endcase
    return 1'b0;
  endfunction

  task automatic checkState(input string tag);
    for (int i = 0; i < 16; i++) begin
      rdIdx = 4'(i); #1;
      chk(32'(rdData), 32'(m[i]), $sformatf("%s reg %0d", tag, i));
    end
    chk(32'(errFlag), 32'd0, "R10 pulse ended");
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 2; s++) begin
        segMode = s[0]; regA = 4'(i); #1;
        chk(packedAddr, expPack(i, s[0]), s[0] ? $sformatf("R2 packed %0d", i)
                                                : $sformatf("R3 packed %0d", i));
      end
    end
  endtask

  task automatic doOp(input int op, input int a, input int b, input logic [15:0] stp,
                      input logic [31:0] ad, input bit s, input bit v, input string tag);
    bit expErr = 1'b0;
    @(negedge clk);
    opCode = 3'(op); regA = 4'(a); regB = 4'(b); stepIn = stp; addrIn = ad;
    segMode = s; valid = v;
    if (v) expErr = model(op, a, b, stp, ad, s);
    @(negedge clk);
    valid = 1'b0;
    chk(32'(errFlag), 32'(expErr), expErr ? "R10 error raised" : $sformatf("%s no error", tag));
    checkState(expErr ? "R10 state kept" : tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    logic [15:0] steps [4];
    steps[0] = 16'h0001; steps[1] = 16'h0002; steps[2] = 16'h8000; steps[3] = 16'hFFFF;
    for (int i = 0; i < 16; i++) m[i] = 16'h0000;

    // R1: reset state
    repeat (2) @(negedge clk);
    rdIdx = 4'd5; #1;
    chk(32'(rdData), 32'd0, "R1 reg during reset");
    chk(32'(errFlag), 32'd0, "R1 err during reset");
    segMode = 1'b1; regA = 4'd0; #1;
    chk(packedAddr, 32'h8000_0000, "R1 packed seg during reset");
    @(negedge clk); rstN = 1'b1;
    checkState("R1");

    // R12: fill every register in both modes
    for (int i = 0; i < 16; i++) begin
      nextRnd(r);
      doOp(7, i, 0, r[15:0], 32'h0, i[0], 1'b1, "R12");
    end

    // R4: write-packed with junk in bits 31 and 23:16
    for (int p = 0; p < 8; p++) begin
      doOp(7, 2 * p, 0, 16'h80A5, 32'h0, 1'b0, 1'b1, "R12");
      for (int k = 0; k < 3; k++) begin
        nextRnd(r);
        doOp(6, 2 * p, 0, 16'h0, r, 1'b1, 1'b1, "R4");
      end
    end
    nextRnd(r);
    doOp(6, 5, 0, 16'h0, r, 1'b0, 1'b1, "R4 flat");

    // R5/R6: add and subtract, with offsets parked at the wrap edges
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int op = 1; op <= 2; op++) begin
          for (int k = 0; k < 4; k++) begin
            doOp(7, a | s, 0, (op == 1) ? 16'hFFFF : 16'h0000, 32'h0, 1'b0, 1'b1, "R12");
            doOp(op, a, 0, steps[k], 32'h0, s[0], 1'b1, s[0] ? "R5" : "R6");
          end
        end
      end
    end

    // R7: load-address with displacement, including source == target
    for (int a = 0; a < 16; a += 2) begin
      for (int b = 0; b < 16; b += 2) begin
        nextRnd(r);
        doOp(3, a, b, r[15:0], 32'h0, 1'b1, 1'b1, "R7 seg");
      end
    end
    for (int a = 0; a < 16; a++) begin
      nextRnd(r);
      doOp(3, a, 15 - a, r[15:0], 32'h0, 1'b0, 1'b1, "R7 flat");
    end
    doOp(3, 2, 7, 16'h0003, 32'h0, 1'b1, 1'b1, "R10 odd source");
    doOp(3, 9, 4, 16'h0003, 32'h0, 1'b1, 1'b1, "R10 odd target");

    // R8/R9: absolute loads, indexed by a base that may be the target
    for (int a = 0; a < 16; a++) begin
      nextRnd(r); nextRnd(r2);
      doOp(4, a, 0, 16'h0, r, a[0], 1'b1, "R8");
      doOp(5, a, r2[3:0], 16'h0, r2, a[0], 1'b1, "R9");
      doOp(5, a, a | 1, 16'h0, r2 ^ 32'h0000_FFF0, 1'b1, 1'b1, "R9 seg");
    end

    // R10: every pair operation with an odd target in segmented mode
    for (int op = 1; op <= 6; op++) begin
      nextRnd(r);
      doOp(op, 2 * op - 1, 0, r[15:0], r, 1'b1, 1'b1, "R10");
    end

    // R11: strobe low with live-looking inputs
    for (int op = 1; op <= 7; op++) begin
      nextRnd(r);
      doOp(op, op, 2, r[15:0], r, op[0], 1'b0, "R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule